// File: doc/BRIEF.md
# Ready-Instruction Priority Selector

This block picks the next instruction to issue from an out-of-order issue queue. Every queue slot presents a valid bit, a ready bit, a program-order age index, a count of known dependent consumers and a mask of the pipeline resources it needs. Each cycle the block looks at all slots at once and chooses one slot that is ready and whose resources are all free. The winner is the slot with the lowest rank, where rank is the age index minus the consumer count. This favours slots that are both old and heavily depended upon.

Ready slots that lose only because a resource is taken are not dropped silently. Their missing resources are collected into a busy mask, which is rebuilt from scratch every cycle. The block also reports the highest-numbered resource in that mask, so stall analysis can name one blocking unit. Every output is registered, so results appear one clock after the inputs are sampled.

Top module: `isel_top`

## Requirements
- R1: The rank of a slot is its age index minus its consumer count. It is computed as a signed value one bit wider than the wider of the two fields, so it never overflows. Among candidates, the lowest rank is chosen, and negative ranks are allowed.
- R2: When two candidates have equal rank, the one with the smaller age index wins. When both rank and age are equal, the lower slot number wins.
- R3: A slot is a candidate only when its valid bit is 1, its ready bit is 1, and every bit set in its need mask is also set in `res_free`. A slot whose valid bit is 0 is never selected, even if its ready bit is 1.
- R4: When there is no candidate, `sel_vld_q` is 0, `grant_q` is all zeros and `sel_idx_q` is 0.
- R5: All outputs are registered. Inputs applied before a rising edge appear at the outputs only after that edge.
- R6: When `sel_vld_q` is 1, `grant_q` has exactly one bit set, at position `sel_idx_q`.
- R7: Bit b of `busy_q` is 1 exactly when some slot that is valid and ready needed resource b while `res_free[b]` was 0, in the sampled cycle. Nothing carries over from earlier cycles.
- R8: `busy_top_q` is the position of the most significant set bit of `busy_q`, and `busy_top_vld_q` is 1 when `busy_q` is nonzero. When `busy_q` is zero, both are 0.
- R9: While the synchronous active-high reset `rst` is 1, every output is cleared at each rising edge.
- R10: A blocked slot with a better rank does not stop a worse-ranked slot whose resources fit from being selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ent_valid | input | N | Slot holds an instruction |
| ent_ready | input | N | Slot operands are ready |
| ent_age | input | N*AGE_W | Age index per slot, slot i at bits [i*AGE_W +: AGE_W] |
| ent_users | input | N*CNT_W | Consumer count per slot |
| ent_need | input | N*RES_W | Needed resource mask per slot |
| res_free | input | RES_W | Resources free this cycle |
| grant_q | output | N | One-hot grant to the winning slot |
| sel_idx_q | output | $clog2(N) | Winning slot number |
| sel_vld_q | output | 1 | A winner exists |
| busy_q | output | RES_W | Resources that blocked ready slots |
| busy_top_q | output | $clog2(RES_W) | Highest set bit of busy_q |
| busy_top_vld_q | output | 1 | busy_q is nonzero |

## Verification
A wrong comparison in the selection tree shows up as a wrong `sel_idx_q` or `grant_q` exactly one clock after the offending inputs are applied. Ties, negative ranks and padding leaves are the likely places for such errors. A busy mask that kept stale bits, or missed a blocked slot, differs from the expected mask on that same registered edge. Because every output is rebuilt each cycle from the current inputs, no fault can hide for more than one clock. The cycle-by-cycle comparison therefore localises each error to the inputs of a single cycle.

// File: rtl/isel_pkg.sv
package isel_pkg;
  localparam int DEF_ENTRIES = 8;
  localparam int DEF_AGE_W   = 6;
  localparam int DEF_CNT_W   = 4;
  localparam int DEF_RES_W   = 4;

  // signed rank width: one bit above the wider operand
  function automatic int rank_width(input int age_w, input int cnt_w);
    return ((age_w > cnt_w) ? age_w : cnt_w) + 1;
  endfunction
endpackage

// File: rtl/isel_entry_eval.sv
module isel_entry_eval #(
  parameter int AGE_W  = 6,
  parameter int CNT_W  = 4,
  parameter int RES_W  = 4,
  parameter int RANK_W = isel_pkg::rank_width(AGE_W, CNT_W)
) (
  input  logic                     valid,
  input  logic                     ready,
  input  logic [AGE_W-1:0]         age,
  input  logic [CNT_W-1:0]         users,
  input  logic [RES_W-1:0]         need,
  input  logic [RES_W-1:0]         free_res,
  output logic                     cand,
  output logic signed [RANK_W-1:0] rank,
  output logic [RES_W-1:0]         blocked
);
  logic [RES_W-1:0] missing;
  logic             live;

  always_comb begin
    live    = valid & ready;
    missing = need & ~free_res;
    cand    = live & (missing == '0);
    blocked = live ? missing : '0;
    rank    = $signed({{(RANK_W-AGE_W){1'b0}}, age})
            - $signed({{(RANK_W-CNT_W){1'b0}}, users});
  end
endmodule

// File: rtl/isel_pick_tree.sv
module isel_pick_tree #(
  parameter int N      = 8,
  parameter int AGE_W  = 6,
  parameter int RANK_W = 7,
  localparam int IDX_W = $clog2(N),
  localparam int LVL   = $clog2(N),
  localparam int P     = 1 << LVL,
  localparam int NODES = 2 * P - 1
) (
  input  logic [N-1:0]             cand,
  input  logic [N*RANK_W-1:0]      ranks,
  input  logic [N*AGE_W-1:0]       ages,
  output logic                     win_vld,
  output logic [IDX_W-1:0]         win_idx
);
  logic                     n_vld  [NODES];
  logic signed [RANK_W-1:0] n_rank [NODES];
  logic [AGE_W-1:0]         n_age  [NODES];
  logic [IDX_W-1:0]         n_idx  [NODES];

  for (genvar i = 0; i < P; i++) begin : g_leaf
    if (i < N) begin : g_real
      assign n_vld[P-1+i]  = cand[i];
      assign n_rank[P-1+i] = $signed(ranks[i*RANK_W +: RANK_W]);
      assign n_age[P-1+i]  = ages[i*AGE_W +: AGE_W];
      assign n_idx[P-1+i]  = IDX_W'(i);
    end else begin : g_pad
      assign n_vld[P-1+i]  = 1'b0;
      assign n_rank[P-1+i] = '0;
      assign n_age[P-1+i]  = '0;
      assign n_idx[P-1+i]  = '0;
    end
  end

  // left subtree always holds lower slot numbers: full ties keep left
  for (genvar k = 0; k < P - 1; k++) begin : g_node
    logic take_r;
    assign take_r = n_vld[2*k+2] &
                    (!n_vld[2*k+1] ||
                     (n_rank[2*k+2] < n_rank[2*k+1]) ||
                     ((n_rank[2*k+2] == n_rank[2*k+1]) &&
                      (n_age[2*k+2] < n_age[2*k+1])));
    assign n_vld[k]  = n_vld[2*k+1] | n_vld[2*k+2];
    assign n_rank[k] = take_r ? n_rank[2*k+2] : n_rank[2*k+1];
    assign n_age[k]  = take_r ? n_age[2*k+2]  : n_age[2*k+1];
    assign n_idx[k]  = take_r ? n_idx[2*k+2]  : n_idx[2*k+1];
  end

  assign win_vld = n_vld[0];
  assign win_idx = n_vld[0] ? n_idx[0] : '0;
endmodule

// File: rtl/isel_msb_enc.sv
module isel_msb_enc #(
  parameter int W = 4,
  localparam int ID_W = $clog2(W)
) (
  input  logic [W-1:0]    mask,
  output logic [ID_W-1:0] id,
  output logic            any
);
  always_comb begin
    id = '0;
    for (int b = 0; b < W; b++) begin
      if (mask[b]) id = ID_W'(b);
    end
    any = |mask;
  end
endmodule

// File: rtl/isel_top.sv
module isel_top #(
  parameter int N     = isel_pkg::DEF_ENTRIES,
  parameter int AGE_W = isel_pkg::DEF_AGE_W,
  parameter int CNT_W = isel_pkg::DEF_CNT_W,
  parameter int RES_W = isel_pkg::DEF_RES_W,
  localparam int IDX_W  = $clog2(N),
  localparam int RID_W  = $clog2(RES_W),
  localparam int RANK_W = isel_pkg::rank_width(AGE_W, CNT_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N-1:0]       ent_valid,
  input  logic [N-1:0]       ent_ready,
  input  logic [N*AGE_W-1:0] ent_age,
  input  logic [N*CNT_W-1:0] ent_users,
  input  logic [N*RES_W-1:0] ent_need,
  input  logic [RES_W-1:0]   res_free,
  output logic [N-1:0]       grant_q,
  output logic [IDX_W-1:0]   sel_idx_q,
  output logic               sel_vld_q,
  output logic [RES_W-1:0]   busy_q,
  output logic [RID_W-1:0]   busy_top_q,
  output logic               busy_top_vld_q
);
  logic [N-1:0]        cand;
  logic [N*RANK_W-1:0] ranks;
  logic [RES_W-1:0]    blk   [N];
  logic [RES_W-1:0]    busy_d;
  logic                win_vld;
  logic [IDX_W-1:0]    win_idx;
  logic [RID_W-1:0]    top_id;
  logic                top_any;

  for (genvar i = 0; i < N; i++) begin : g_ent
    logic signed [RANK_W-1:0] r;
    isel_entry_eval #(.AGE_W(AGE_W), .CNT_W(CNT_W), .RES_W(RES_W), .RANK_W(RANK_W)) u_eval (
      .valid   (ent_valid[i]),
      .ready   (ent_ready[i]),
      .age     (ent_age[i*AGE_W +: AGE_W]),
      .users   (ent_users[i*CNT_W +: CNT_W]),
      .need    (ent_need[i*RES_W +: RES_W]),
      .free_res(res_free),
      .cand    (cand[i]),
      .rank    (r),
      .blocked (blk[i])
    );
    assign ranks[i*RANK_W +: RANK_W] = r;
  end

  always_comb begin
    busy_d = '0;
    for (int i = 0; i < N; i++) busy_d |= blk[i];
  end

  isel_pick_tree #(.N(N), .AGE_W(AGE_W), .RANK_W(RANK_W)) u_tree (
    .cand   (cand),
    .ranks  (ranks),
    .ages   (ent_age),
    .win_vld(win_vld),
    .win_idx(win_idx)
  );

  isel_msb_enc #(.W(RES_W)) u_msb (
    .mask(busy_d),
    .id  (top_id),
    .any (top_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q        <= '0;
      sel_idx_q      <= '0;
      sel_vld_q      <= 1'b0;
      busy_q         <= '0;
      busy_top_q     <= '0;
      busy_top_vld_q <= 1'b0;
    end else begin
      grant_q        <= win_vld ? (N'(1) << win_idx) : '0;
      sel_idx_q      <= win_idx;
      sel_vld_q      <= win_vld;
      busy_q         <= busy_d;
      busy_top_q     <= top_id;
      busy_top_vld_q <= top_any;
    end
  end
endmodule

// File: rtl/isel_top_chk.sv
module isel_top_chk #(
  parameter int N = 8,
  parameter int AGE_W = 6,
  parameter int CNT_W = 4,
  parameter int RES_W = 4,
  localparam int IDX_W = $clog2(N),
  localparam int RID_W = $clog2(RES_W)
) (
  input logic               clk,
  input logic               rst,
  input logic [N-1:0]       ent_valid,
  input logic [N-1:0]       ent_ready,
  input logic [N*RES_W-1:0] ent_need,
  input logic [RES_W-1:0]   res_free,
  input logic [N-1:0]       grant_q,
  input logic [IDX_W-1:0]   sel_idx_q,
  input logic               sel_vld_q,
  input logic [RES_W-1:0]   busy_q,
  input logic [RID_W-1:0]   busy_top_q,
  input logic               busy_top_vld_q
);
  logic [N-1:0] fits;
  always_comb begin
    for (int i = 0; i < N; i++)
      fits[i] = ent_valid[i] & ent_ready[i] & ((ent_need[i*RES_W +: RES_W] & ~res_free) == '0);
  end

  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q) && (sel_vld_q == (grant_q != '0)));
  p_sel_legal_r3: assert property (@(posedge clk) disable iff (rst)
    sel_vld_q |-> ((($past(fits) >> sel_idx_q) & N'(1)) != '0));
  p_none_invalid_r4: assert property (@(posedge clk) disable iff (rst)
    (fits == '0) |=> (!sel_vld_q && grant_q == '0));
  p_busy_subset_r7: assert property (@(posedge clk) disable iff (rst)
    (ent_valid & ent_ready) == '0 |=> busy_q == '0);
  p_busy_free_r7: assert property (@(posedge clk) disable iff (rst)
    ##1 ((busy_q & $past(res_free)) == '0));
  p_top_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_top_vld_q == (busy_q != '0)) && (busy_top_vld_q || busy_top_q == '0));
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!sel_vld_q && busy_q == '0 && !busy_top_vld_q));
endmodule

bind isel_top isel_top_chk #(.N(N), .AGE_W(AGE_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst(rst), .ent_valid(ent_valid), .ent_ready(ent_ready),
  .ent_need(ent_need), .res_free(res_free), .grant_q(grant_q),
  .sel_idx_q(sel_idx_q), .sel_vld_q(sel_vld_q), .busy_q(busy_q),
  .busy_top_q(busy_top_q), .busy_top_vld_q(busy_top_vld_q)
);

// File: tb/isel_top_tb.sv
module isel_top_tb;
  localparam int N = 8, AGE_W = 6, CNT_W = 4, RES_W = 4;
  localparam int IDX_W = $clog2(N), RID_W = $clog2(RES_W);

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] ent_valid, ent_ready;
  logic [N*AGE_W-1:0] ent_age;
  logic [N*CNT_W-1:0] ent_users;
  logic [N*RES_W-1:0] ent_need;
  logic [RES_W-1:0] res_free;
  logic [N-1:0] grant_q;
  logic [IDX_W-1:0] sel_idx_q;
  logic sel_vld_q;
  logic [RES_W-1:0] busy_q;
  logic [RID_W-1:0] busy_top_q;
  logic busy_top_vld_q;

  int total = 0, bad = 0;
  int e_vld, e_idx, e_busy, e_top, e_topv;

  always #2 clk = ~clk;

  isel_top #(.N(N), .AGE_W(AGE_W), .CNT_W(CNT_W), .RES_W(RES_W)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    ent_valid = '0; ent_ready = '0; ent_age = '0; ent_users = '0;
    ent_need = '0; res_free = '1;
  endtask

  task automatic set_ent(input int i, input int v, input int r, input int a, input int u, input int nd);
    ent_valid[i] = v[0]; ent_ready[i] = r[0];
    ent_age[i*AGE_W +: AGE_W] = AGE_W'(a);
    ent_users[i*CNT_W +: CNT_W] = CNT_W'(u);
    ent_need[i*RES_W +: RES_W] = RES_W'(nd);
  endtask

  // behavioural reference from the requirements
  task automatic model();
    int best_r, best_a;
    e_vld = 0; e_idx = 0; e_busy = 0; e_top = 0; e_topv = 0;
    best_r = 0; best_a = 0;
    for (int i = 0; i < N; i++) begin
      int a, u, nd, miss, rk;
      a = int'(ent_age[i*AGE_W +: AGE_W]);
      u = int'(ent_users[i*CNT_W +: CNT_W]);
      nd = int'(ent_need[i*RES_W +: RES_W]);
      miss = nd & ~int'(res_free);
      rk = a - u;
      if (ent_valid[i] && ent_ready[i]) begin
        if (miss != 0) e_busy = e_busy | miss;
        else if (!e_vld || rk < best_r || (rk == best_r && a < best_a)) begin
          e_vld = 1; e_idx = i; best_r = rk; best_a = a;
        end
      end
    end
    for (int b = 0; b < RES_W; b++) if (e_busy[b]) begin e_top = b; e_topv = 1; end
  endtask

  task automatic run(input string tag);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(sel_vld_q), e_vld);
    chk(tag, int'(sel_idx_q), e_idx);
    chk("R6", int'(grant_q), e_vld ? (1 << e_idx) : 0);
    chk("R7", int'(busy_q), e_busy);
    chk("R8", int'(busy_top_q), e_top);
    chk("R8", int'(busy_top_vld_q), e_topv);
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    clear_in();
    for (int i = 0; i < N; i++) set_ent(i, 1, 1, i, 0, 0);
    repeat (3) @(negedge clk);
    // R9: reset holds outputs clear despite candidates
    chk("R9", int'(sel_vld_q), 0);
    chk("R9", int'(grant_q), 0);
    chk("R9", int'(busy_q), 0);
    clear_in();
    @(negedge clk);
    rst = 1'b0;
    run("R4");
    // R5: new inputs do not reach outputs before an edge
    set_ent(3, 1, 1, 5, 0, 0);
    #1;
    chk("R5", int'(sel_vld_q), 0);
    run("R5");
    // R1: younger slot with many users wins
    clear_in(); set_ent(0, 1, 1, 10, 0, 0); set_ent(3, 1, 1, 12, 5, 0);
    run("R1");
    chk("R1", int'(sel_idx_q), 3);
    // R1: negative rank
    clear_in(); set_ent(1, 1, 1, 0, 0, 0); set_ent(6, 1, 1, 2, 15, 0);
    run("R1");
    chk("R1", int'(sel_idx_q), 6);
    // R2: equal rank, older wins
    clear_in(); set_ent(1, 1, 1, 9, 2, 0); set_ent(5, 1, 1, 8, 1, 0);
    run("R2");
    chk("R2", int'(sel_idx_q), 5);
    // R2: full tie, lower slot wins
    clear_in(); set_ent(2, 1, 1, 4, 0, 0); set_ent(6, 1, 1, 4, 0, 0);
    run("R2");
    chk("R2", int'(sel_idx_q), 2);
    // R3: invalid slot with stale ready bit is ignored
    clear_in(); set_ent(4, 0, 1, 0, 9, 0); set_ent(7, 1, 1, 30, 0, 0);
    run("R3");
    chk("R3", int'(sel_idx_q), 7);
    // R4: all ready slots blocked
    clear_in(); res_free = 4'b0000;
    set_ent(0, 1, 1, 1, 0, 4'b0010); set_ent(5, 1, 1, 3, 0, 4'b0100);
    run("R4");
    chk("R4", int'(sel_vld_q), 0);
    chk("R8", int'(busy_top_q), 2);
    // R10 and R7: blocked better slot, fitting worse slot wins
    clear_in(); res_free = 4'b0111;
    set_ent(0, 1, 1, 1, 0, 4'b1000); set_ent(2, 1, 1, 20, 0, 4'b0001);
    run("R10");
    chk("R10", int'(sel_idx_q), 2);
    chk("R7", int'(busy_q), 8);
    // R7: busy cleared the next cycle
    clear_in();
    run("R7");
    chk("R7", int'(busy_q), 0);
    // random traffic compared every cycle
    for (int c = 0; c < 400; c++) begin
      ent_valid = N'($urandom); ent_ready = N'($urandom);
      ent_age = {$urandom, $urandom};
      ent_users = N*CNT_W'($urandom);
      ent_need = N*RES_W'($urandom) & N*RES_W'($urandom);
      res_free = RES_W'($urandom | $urandom);
      run("R1");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule